// File: doc/BRIEF.md
# Ring Buffer Free-Space Watchdog

This block decides whether a producer may append a batch of words to a circular command ring. A consumer moves a head pointer forward as it drains the ring. The producer owns the tail pointer. When the producer pulses a start strobe, the block latches the amount of room it needs. From then on it checks the free space on every clock cycle. It grants the request as soon as the room is available.

If the room is not yet there, the block keeps polling, and it tolerates any amount of waiting while the consumer is still advancing. It reports a busy error only when the head pointer has stayed unchanged for a fixed number of consecutive polls. A long but steady drain therefore never raises an error. Only a consumer that has really stopped does.

A separate drain mode asks for the largest amount of room the ring can ever offer. A producer uses it to wait until the consumer has caught up completely. A combinational flag shows at all times whether the ring holds no work.

Top module: `ring_space_watchdog`

## Requirements
- R1: Pointers are byte addresses. Only the bits below log2(ringSize) are used, and bits 1:0 are also ignored, so higher bits and sub-word bits of headPtr and tailPtr have no effect on any output. ringSize is a power of two, at least 16.
- R2: Free space is headM - tailM - 8, plus ringSize when that difference is negative. On each poll edge, the request is granted when the free space is greater than or equal to the latched request. The first poll edge is the one after the edge that accepts reqStart. grant is a single-cycle pulse that follows that edge.
- R3: When POLL_LIMIT consecutive poll edges see too little space and an unchanged head, busyErr pulses for a single cycle after the last of those edges, and the request ends.
- R4: A poll edge that sees a masked head different from the one seen at the previous poll edge (or at the start edge) restarts the stall count. The error then comes exactly POLL_LIMIT poll edges after the last head movement.
- R5: waiting is high in every cycle in which a request is pending and the current free space is below the latched request. It is low in all other cycles, including reset.
- R6: ringEmpty is high exactly when the masked head equals the masked tail, independently of any request.
- R7: With reqDrain high at start, reqBytes is ignored and the request becomes ringSize - 8.
- R8: A reqStart that arrives while a request is pending is ignored, together with its reqBytes and reqDrain.
- R9: grant and busyErr are never high in the same cycle. Both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headPtr | input | ADDR_W | Consumer head byte address |
| tailPtr | input | ADDR_W | Producer tail byte address |
| ringSize | input | ADDR_W+1 | Ring size in bytes, power of two |
| reqBytes | input | ADDR_W+1 | Room needed, in bytes |
| reqDrain | input | 1 | Request full-drain room instead of reqBytes |
| reqStart | input | 1 | Single-cycle request strobe |
| grant | output | 1 | Room available, single-cycle pulse |
| busyErr | output | 1 | Consumer stalled, single-cycle pulse |
| waiting | output | 1 | Pending request lacks room this cycle |
| ringEmpty | output | 1 | Masked head equals masked tail |

## Verification
The properties assume that ringSize stays constant while a request is pending and that reqStart is a single-cycle pulse. They also assume the head moves only between clock edges, so a poll never sees a half-updated pointer. The bench changes the pointers and the size only at falling edges. It changes ringSize only between requests. It moves the head only inside the windows planned for the progress tests, and it keeps each movement small enough that the free space stays below the request until the test means to cross it.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;  // latch request, seed head history, clear stall count
    logic track;    // failed poll: update head history and stall count
  } dpStrobe_t;

  // status returned by the datapath
  typedef struct packed {
    logic enough;     // free space covers the latched request
    logic stallDone;  // this failed poll completes the stall window
  } dpStatus_t;

endpackage

// File: rtl/rsw_datapath.sv
module rsw_datapath
  import rsw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int POLL_LIMIT = 10000,
  parameter int RESERVE    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic [ADDR_W-1:0] tailPtr,
  input  logic [ADDR_W:0]   ringSize,
  input  logic [ADDR_W:0]   reqBytes,
  input  logic              reqDrain,
  input  dpStrobe_t         strobe,
  output dpStatus_t         status,
  output logic              ringEmpty
);

  localparam int SPACE_W = ADDR_W + 2;
  localparam int CNT_W   = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(POLL_LIMIT - 1);

  logic [ADDR_W-1:0] sizeMask, ptrMask, headM, tailM, lastHead;
  logic [ADDR_W:0]   reqLatched;
  logic [CNT_W-1:0]  stallCnt;
  logic signed [SPACE_W-1:0] rawDiff, freeSpace, reqWide;
  logic headMoved;

  // address-field masking: ring range and word alignment
  always_comb begin
    sizeMask = ADDR_W'(ringSize - 1'b1);
    ptrMask  = sizeMask & ALIGN_MASK;
    headM    = headPtr & ptrMask;
    tailM    = tailPtr & ptrMask;
  end

  // free space with wrap correction
  always_comb begin
    rawDiff   = $signed({2'b00, headM}) - $signed({2'b00, tailM})
              - $signed(SPACE_W'(RESERVE));
    freeSpace = (rawDiff < 0) ? rawDiff + $signed({1'b0, ringSize}) : rawDiff;
    reqWide   = $signed({1'b0, reqLatched});
  end

  assign headMoved        = (headM != lastHead);
  assign status.enough    = (freeSpace >= reqWide);
  assign status.stallDone = !headMoved && (stallCnt == CNT_LAST);
  assign ringEmpty        = (headM == tailM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLatched <= '0;
      lastHead   <= '0;
      stallCnt   <= '0;
    end else if (strobe.capture) begin
      reqLatched <= reqDrain ? ringSize - (ADDR_W+1)'(RESERVE) : reqBytes;
      lastHead   <= headM;
      stallCnt   <= '0;
    end else if (strobe.track) begin
      lastHead   <= headM;
      stallCnt   <= headMoved ? '0 : stallCnt + 1'b1;
    end
  end

endmodule

// File: rtl/rsw_control.sv
module rsw_control
  import rsw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqStart,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      grant,
  output logic      busyErr,
  output logic      waiting
);

  typedef enum logic {ST_IDLE, ST_POLL} ctlState_t;
  ctlState_t state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && reqStart;
    strobe.track   = (state == ST_POLL) && !status.enough;
    waiting        = (state == ST_POLL) && !status.enough;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      grant   <= 1'b0;
      busyErr <= 1'b0;
    end else begin
      grant   <= 1'b0;
      busyErr <= 1'b0;
      case (state)
        ST_IDLE: if (reqStart) state <= ST_POLL;
        ST_POLL: begin
          if (status.enough) begin
            grant <= 1'b1;
            state <= ST_IDLE;
          end else if (status.stallDone) begin
            busyErr <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ring_space_watchdog.sv
module ring_space_watchdog
  import rsw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int POLL_LIMIT = 10000,
  parameter int RESERVE    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic [ADDR_W-1:0] tailPtr,
  input  logic [ADDR_W:0]   ringSize,
  input  logic [ADDR_W:0]   reqBytes,
  input  logic              reqDrain,
  input  logic              reqStart,
  output logic              grant,
  output logic              busyErr,
  output logic              waiting,
  output logic              ringEmpty
);

  dpStrobe_t strobe;
  dpStatus_t status;

  rsw_datapath #(
    .ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT), .RESERVE(RESERVE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .headPtr(headPtr), .tailPtr(tailPtr),
    .ringSize(ringSize), .reqBytes(reqBytes), .reqDrain(reqDrain),
    .strobe(strobe), .status(status), .ringEmpty(ringEmpty)
  );

  rsw_control ctl_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .status(status),
    .strobe(strobe), .grant(grant), .busyErr(busyErr), .waiting(waiting)
  );

endmodule

// File: rtl/rsw_checker.sv
module rsw_checker (
  input logic clk,
  input logic rstN,
  input logic grant,
  input logic busyErr,
  input logic waiting
);

  // R2: a grant lasts exactly one cycle
  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);

  // R3: a busy error lasts exactly one cycle
  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |=> !busyErr);

  // R3: an error only ends a request that was short of room
  assert_err_after_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> $past(waiting));

  // R9: the two outcomes never coincide
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && busyErr));

  // R5: waiting is low once the request has ended
  assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (grant || busyErr) |-> !waiting);

endmodule

bind ring_space_watchdog rsw_checker chk_i (
  .clk(clk), .rstN(rstN), .grant(grant), .busyErr(busyErr), .waiting(waiting)
);

// File: tb/ring_space_watchdog_tb.sv
module ring_space_watchdog_tb_top;

  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int LIMIT  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] headPtr = '0, tailPtr = '0;
  logic [AW:0]   ringSize = 7'd64, reqBytes = '0;
  logic          reqDrain = 1'b0, reqStart = 1'b0;
  logic          grant, busyErr, waiting, ringEmpty;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ring_space_watchdog #(.ADDR_W(AW), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .headPtr(headPtr), .tailPtr(tailPtr),
    .ringSize(ringSize), .reqBytes(reqBytes), .reqDrain(reqDrain),
    .reqStart(reqStart), .grant(grant), .busyErr(busyErr),
    .waiting(waiting), .ringEmpty(ringEmpty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int spaceOf(input int h, input int t, input int sz);
    int s;
    s = h - (t + 8);
    if (s < 0) s += sz;
    return s;
  endfunction

  // one request with constant pointers; junk lands in ignored bits (R1)
  task automatic runTxn(input int h, input int t, input int sz, input int req,
                        input bit drain, input int junk);
    int pm, s, need, k;
    bit expG, ok;
    pm = (sz - 1) & ~3;
    s = spaceOf(h, t, sz);
    need = drain ? sz - 8 : req;
    expG = (s >= need);
    @(negedge clk);
    headPtr  = AW'((h & pm) | (junk & ~pm & 63));
    tailPtr  = AW'((t & pm) | ((junk * 5) & ~pm & 63));
    ringSize = (AW+1)'(sz);
    reqBytes = (AW+1)'(drain ? 63 : req);
    reqDrain = drain;
    reqStart = 1'b1;
    #1;
    chk(ringEmpty == (h == t), "R6 empty flag", ringEmpty, h == t);
    @(negedge clk);
    reqStart = 1'b0;
    #1;
    chk(waiting == !expG, "R5 waiting while short", waiting, !expG);
    ok = 1'b1;
    for (k = 1; k <= LIMIT + 1; k++) begin
      @(negedge clk);
      if (grant != (expG && k == 1)) ok = 1'b0;
      if (busyErr != (!expG && k == LIMIT)) ok = 1'b0;
    end
    chk(ok, drain ? "R7 drain outcome" : (expG ? "R2 grant timing" : "R3 error timing"),
        {grant, busyErr}, expG);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int moves, lastMove, p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!grant && !busyErr && !waiting, "R9 reset state", {grant, busyErr, waiting}, 0);

    // sweep: sizes, every aligned head and tail, boundary requests (R1 R2 R3 R6 R7)
    for (int szi = 0; szi < 3; szi++) begin
      int sz;
      sz = 16 << szi;
      for (int h = 0; h < sz; h += 4) begin
        for (int t = 0; t < sz; t += 4) begin
          int s;
          s = spaceOf(h, t, sz);
          runTxn(h, t, sz, (s < 0) ? 0 : s, 1'b0, h * 7 + t * 3 + 1);
          runTxn(h, t, sz, (s < 0) ? 0 : s + 4, 1'b0, h + t * 11 + 2);
          runTxn(h, t, sz, 0, 1'b1, h * 13 + t + 3);
        end
      end
    end

    // R4: head keeps moving, error only after it stops
    @(negedge clk);
    ringSize = 7'd64; tailPtr = 6'd32; headPtr = 6'd0;
    reqBytes = 7'd56; reqDrain = 1'b0; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    moves = 0; lastMove = 0;
    for (p = 1; p <= 60; p++) begin
      if (p % 5 == 0 && moves < 7) begin
        headPtr = headPtr + 6'd4;
        moves++;
        lastMove = p;
      end
      @(negedge clk);
      chk(busyErr == (p == lastMove + LIMIT) && !grant, "R4 stall restart",
          busyErr, p == lastMove + LIMIT);
      if (busyErr) break;
    end
    chk(p == 43, "R4 error poll index", p, 43);

    // R2: head progress opens room mid-request
    @(negedge clk);
    tailPtr = 6'd32; headPtr = 6'd0; reqBytes = 7'd28; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (p = 1; p <= 4; p++) begin
      if (p == 3) headPtr = 6'd4;
      @(negedge clk);
      chk(grant == (p == 3) && !busyErr, "R2 grant after progress", grant, p == 3);
    end

    // R8: second start while pending is ignored
    @(negedge clk);
    tailPtr = 6'd32; headPtr = 6'd0; reqBytes = 7'd56; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (p = 1; p <= LIMIT + 1; p++) begin
      if (p == 3) begin reqStart = 1'b1; reqBytes = 7'd0; end
      else reqStart = 1'b0;
      #1;
      chk(p > LIMIT || waiting, "R8 still waiting", waiting, 1);
      @(negedge clk);
      chk(grant == 1'b0 && busyErr == (p == LIMIT), "R8 ignored restart",
          {grant, busyErr}, (p == LIMIT) ? 1 : 0);
    end
    reqStart = 1'b0;

    // R6: empty flag with no request, high bits differ (R1)
    @(negedge clk);
    ringSize = 7'd16; headPtr = 6'b110101; tailPtr = 6'b000100;
    #1;
    chk(ringEmpty == 1'b1, "R6 R1 empty ignores upper bits", ringEmpty, 1);
    headPtr = 6'b001000;
    #1;
    chk(ringEmpty == 1'b0, "R6 not empty", ringEmpty, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule